// File: doc/BRIEF.md
# Low-Power Interrupt Capture and Replay

This block sits on a set of external interrupt lines in an always-on area, in front of a parent interrupt controller that may lose power. While the parent is up and recording is off, each line passes to the parent through one register. Before the parent is powered down, software discards stale events, selects which lines are edge-type and which edge each one reacts to, and sets the enable and edge-only bits. From then on, every qualifying edge on an unmasked line is stored as a pending bit and nothing reaches the parent.

Once the parent is back, software writes the flush bit. Each pending line then sends exactly one single-cycle pulse to the parent, and all pending bits are dropped in that same operation. Software then clears the enable and edge-only bits, which returns the block to pass-through. Mask, sensitivity and polarity each have a write-one-to-set address and a write-one-to-clear address. Every per-line function is laid out as an array of 32-bit words, one word for each group of 32 lines.

Top module: `irq_replay_top`

## Requirements
- R1: After reset every line is masked, the control register reads 0, no line is pending and `irq_out` is 0.
- R2: Writing a 1 to bit b of word w of a set address sets the attribute of line 32*w+b, and writing a 1 at the matching clear address clears it. Zero bits and bits above NUM_LINES-1 change nothing. Reading either address returns the current attribute word.
- R3: The byte address is fn*64 + word*4. The function codes are status=0, acknowledge=1, mask set=3, mask clear=4, sensitivity set=6, sensitivity clear=7, polarity set=9, polarity clear=10 and control=12. A read returns its data in `rd_data` on the clock after `rd_en`. Words past the last line group, unused codes and the acknowledge address read as 0.
- R4: With control bit 0 (enable) and bit 1 (edge-only) both set, a line whose mask is 0 and whose sensitivity is 1 becomes pending on a rising edge when its polarity is 1 and on a falling edge when its polarity is 0. A read of the status words shows the pending bits. While the enable bit is 0, no line becomes pending.
- R5: A masked line, or a line with sensitivity 0, never becomes pending.
- R6: Writing a 1 to a line's bit at the acknowledge address clears that line's pending bit.
- R7: A control write with bit 2 set makes `irq_out` carry, on the next cycle only, a pulse on each line that was pending. All pending bits are cleared, and the control register afterwards reads bit 2 as 0.
- R8: While the enable bit is 1, `irq_out` is 0 except for flush pulses. While it is 0, `irq_out` equals `irq_in` delayed by one cycle, ORed with any flush pulse.
- R9: An edge that qualifies on a line in the same cycle as that line is cleared by acknowledge or flush leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_in | input | NUM_LINES | External interrupt lines, synchronous to clk |
| irq_out | output | NUM_LINES | Lines toward the parent controller, registered |

## Verification
Two operations can fall in the same cycle: the clearing of a pending bit, by acknowledge or by flush, and a new qualifying edge on that same line. The bench provokes this by changing `irq_in` on the same clock as the acknowledge or flush write. For the flush case, it then checks that the pulse reflects only the old event. In both cases, a later status read must still show the line pending. A design in which the clear wins would read 0 there.

// File: rtl/irq_replay_pkg.sv
package irq_replay_pkg;
  localparam int unsigned WORD_BITS      = 32;
  localparam int unsigned FN_BITS        = 4;
  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_EDGE_BIT  = 1;
  localparam int unsigned CTRL_FLUSH_BIT = 2;

  // Function code is the address field above the 64-byte window of each function.
  typedef enum logic [FN_BITS-1:0] {
    FN_STATUS = 4'd0,
    FN_ACK    = 4'd1,
    FN_MSET   = 4'd3,
    FN_MCLR   = 4'd4,
    FN_SSET   = 4'd6,
    FN_SCLR   = 4'd7,
    FN_PSET   = 4'd9,
    FN_PCLR   = 4'd10,
    FN_CTRL   = 4'd12
  } fn_e;
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_replay_pkg::*;
#(
  parameter int unsigned NUM_LINES = 40,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] sens_q,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] ack_v,
  output logic                 ctrl_en,
  output logic                 ctrl_edge,
  output logic                 flush
);
  localparam int unsigned WORD_W = ADDR_W - FN_BITS - 2;

  logic [FN_BITS-1:0] fn;
  logic [WORD_W-1:0]  word;
  logic               ctrl_hit;
  logic               unused_addr;

  assign fn          = addr[ADDR_W-1 -: FN_BITS];
  assign word        = addr[2 +: WORD_W];
  assign unused_addr = ^addr[1:0];
  assign ctrl_hit    = wr_en && (fn == FN_CTRL) && (word == '0);
  assign flush       = ctrl_hit && wr_data[CTRL_FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_edge <= 1'b0;
    end else if (ctrl_hit) begin
      ctrl_en   <= wr_data[CTRL_EN_BIT];
      ctrl_edge <= wr_data[CTRL_EDGE_BIT];
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int unsigned LW = n / WORD_BITS;
    localparam int unsigned LB = n % WORD_BITS;
    logic hit;
    assign hit      = wr_en && (word == WORD_W'(LW)) && wr_data[LB];
    assign ack_v[n] = hit && (fn == FN_ACK);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[n] <= 1'b1;
        sens_q[n] <= 1'b0;
        pol_q[n]  <= 1'b0;
      end else if (hit) begin
        if (fn == FN_MSET) mask_q[n] <= 1'b1;
        if (fn == FN_MCLR) mask_q[n] <= 1'b0;
        if (fn == FN_SSET) sens_q[n] <= 1'b1;
        if (fn == FN_SCLR) sens_q[n] <= 1'b0;
        if (fn == FN_PSET) pol_q[n]  <= 1'b1;
        if (fn == FN_PCLR) pol_q[n]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int unsigned NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 rec_en,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] sens_q,
  input  logic [NUM_LINES-1:0] pol_q,
  input  logic [NUM_LINES-1:0] clr_v,
  output logic [NUM_LINES-1:0] pending
);
  logic [NUM_LINES-1:0] prev;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;
  logic [NUM_LINES-1:0] cap;

  assign rise = irq_in & ~prev;
  assign fall = ~irq_in & prev;
  assign cap  = {NUM_LINES{rec_en}} & sens_q & ~mask_q &
                ((pol_q & rise) | (~pol_q & fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      pending <= '0;
    end else begin
      prev    <= irq_in;
      pending <= (pending & ~clr_v) | cap;   // a fresh edge outranks the clear
    end
  end
endmodule

// File: rtl/irq_replay_top.sv
module irq_replay_top
  import irq_replay_pkg::*;
#(
  parameter int unsigned NUM_LINES = 40,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic [WORD_BITS-1:0] rd_data,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int unsigned NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS;
  localparam int unsigned PAD_W     = NUM_WORDS * WORD_BITS;
  localparam int unsigned WORD_W    = ADDR_W - FN_BITS - 2;

  logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, ack_v, pend;
  logic                 ctrl_en, ctrl_edge, flush_w;
  logic [PAD_W-1:0]     pad_pend, pad_mask, pad_sens, pad_pol;
  logic [FN_BITS-1:0]   rfn;
  logic [WORD_W-1:0]    rword;
  logic [WORD_BITS-1:0] rd_word;

  irq_reg_file #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mask_q(mask_q), .sens_q(sens_q), .pol_q(pol_q), .ack_v(ack_v),
    .ctrl_en(ctrl_en), .ctrl_edge(ctrl_edge), .flush(flush_w)
  );

  irq_edge_cap #(.NUM_LINES(NUM_LINES)) u_cap (
    .clk(clk), .rst(rst), .irq_in(irq_in), .rec_en(ctrl_en && ctrl_edge),
    .mask_q(mask_q), .sens_q(sens_q), .pol_q(pol_q),
    .clr_v(ack_v | {NUM_LINES{flush_w}}), .pending(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= (flush_w ? pend : '0) | (ctrl_en ? '0 : irq_in);
  end

  assign pad_pend = PAD_W'(pend);
  assign pad_mask = PAD_W'(mask_q);
  assign pad_sens = PAD_W'(sens_q);
  assign pad_pol  = PAD_W'(pol_q);
  assign rfn      = addr[ADDR_W-1 -: FN_BITS];
  assign rword    = addr[2 +: WORD_W];

  always_comb begin
    rd_word = '0;
    if (int'(rword) < NUM_WORDS) begin
      case (rfn)
        FN_STATUS:       rd_word = pad_pend[int'(rword)*WORD_BITS +: WORD_BITS];
        FN_MSET, FN_MCLR: rd_word = pad_mask[int'(rword)*WORD_BITS +: WORD_BITS];
        FN_SSET, FN_SCLR: rd_word = pad_sens[int'(rword)*WORD_BITS +: WORD_BITS];
        FN_PSET, FN_PCLR: rd_word = pad_pol[int'(rword)*WORD_BITS +: WORD_BITS];
        FN_CTRL: if (rword == '0) begin
          rd_word[CTRL_EN_BIT]   = ctrl_en;
          rd_word[CTRL_EDGE_BIT] = ctrl_edge;
        end
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/irq_replay_chk.sv
module irq_replay_chk #(
  parameter int unsigned NUM_LINES = 40
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] mask,
  input logic                 ctrl_en,
  input logic                 flush
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&mask) && (pending == '0) && (irq_out == '0)));  // R1

  AST_NO_MASKED_SET: assert property (@(posedge clk) disable iff (rst)
    (pending & ~$past(pending) & $past(mask)) == '0);  // R5

  AST_FLUSH_REPLAY: assert property (@(posedge clk) disable iff (rst)
    (flush && ctrl_en) |=> (irq_out == $past(pending)));  // R7

  AST_QUIET_WHILE_ON: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_en && !flush) |-> (irq_out == '0));  // R8

  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(!ctrl_en && !flush) |-> (irq_out == $past(irq_in)));  // R8
endmodule

bind irq_replay_top irq_replay_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
  .pending(pend), .mask(mask_q), .ctrl_en(ctrl_en), .flush(flush_w)
);

// File: tb/irq_replay_top_test.sv
module irq_replay_top_test;
  localparam int NL = 40;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  irq_replay_top #(.NUM_LINES(NL), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] adr(input int fn, input int word);
    return AW'(fn * 64 + word * 4);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write with a simultaneous change of the input lines; returns one negedge after the edge.
  task automatic wr_in(input int fn, input int word, input logic [31:0] d, input logic [NL-1:0] iv);
    @(negedge clk);
    wr_en = 1'b1; addr = adr(fn, word); wr_data = d; irq_in = iv;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int fn, input int word, input logic [31:0] d);
    wr_in(fn, word, d, irq_in);
  endtask

  task automatic rd(input int fn, input int word, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = adr(fn, word);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic drive(input logic [NL-1:0] iv);
    @(negedge clk);
    irq_in = iv;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_out after reset", 64'(irq_out), 64'h0);
    rd(3, 0, d); chk("R1 mask word0", 64'(d), 64'hFFFF_FFFF);
    rd(3, 1, d); chk("R1 mask word1", 64'(d), 64'hFF);
    rd(12, 0, d); chk("R1 control", 64'(d), 64'h0);
    rd(0, 0, d); chk("R1 status word0", 64'(d), 64'h0);
    rd(0, 1, d); chk("R1 status word1", 64'(d), 64'h0);
  endtask

  task automatic t_attr;
    logic [31:0] d;
    wr(4, 0, 32'hFF);
    wr(4, 1, 32'h08);
    wr(3, 1, 32'hFFFF_FF00);
    rd(3, 0, d); chk("R2 mask clear word0", 64'(d), 64'hFFFF_FF00);
    rd(4, 1, d); chk("R2 mask word1 via clear addr", 64'(d), 64'hF7);
    wr(6, 0, 32'h10F);
    wr(7, 0, 32'h8);
    rd(6, 0, d); chk("R2 sensitivity set/clear", 64'(d), 64'h107);
    wr(6, 1, 32'h8);
    wr(9, 0, 32'h105);
    wr(9, 1, 32'h8);
    rd(10, 0, d); chk("R2 polarity word0", 64'(d), 64'h105);
    rd(0, 9, d); chk("R3 word past last group", 64'(d), 64'h0);
    rd(15, 0, d); chk("R3 unused function code", 64'(d), 64'h0);
  endtask

  task automatic t_record;
    logic [31:0] d;
    logic [NL-1:0] iv;
    iv = '0; iv[1] = 1'b1; iv[2] = 1'b1;
    drive(iv);
    rd(0, 0, d); chk("R4 no record while disabled", 64'(d), 64'h0);
    wr(12, 0, 32'h3);
    rd(12, 0, d); chk("R4 control enable+edge", 64'(d), 64'h3);
    iv[0] = 1'b1; iv[35] = 1'b1; iv[1] = 1'b0; iv[2] = 1'b0; iv[4] = 1'b1; iv[8] = 1'b1;
    drive(iv);
    chk("R8 output quiet while enabled", 64'(irq_out), 64'h0);
    iv[4] = 1'b0; iv[8] = 1'b0;
    drive(iv);
    rd(0, 0, d);
    chk("R4 status word0 edges", 64'(d), 64'h3);
    chk("R5 masked/level lines not pending", 64'(d & 32'h114), 64'h0);
    rd(0, 1, d); chk("R4 status word1 line35", 64'(d), 64'h8);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    logic [NL-1:0] iv;
    wr(1, 0, 32'h1);
    rd(0, 0, d); chk("R6 acknowledge clears line0", 64'(d), 64'h2);
    iv = irq_in; iv[1] = 1'b1;
    drive(iv);
    iv[1] = 1'b0;
    wr_in(1, 0, 32'h2, iv);
    rd(0, 0, d); chk("R9 edge beats acknowledge", 64'(d), 64'h2);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    logic [NL-1:0] iv, exp;
    iv = irq_in; iv[0] = 1'b0;
    drive(iv);
    iv[0] = 1'b1;
    exp = '0; exp[1] = 1'b1; exp[35] = 1'b1;
    wr_in(12, 0, 32'h7, iv);
    chk("R7 flush pulse lines", 64'(irq_out), 64'(exp));
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 64'(irq_out), 64'h0);
    rd(12, 0, d); chk("R7 flush bit self-clears", 64'(d), 64'h3);
    rd(0, 0, d); chk("R9 edge beats flush", 64'(d), 64'h1);
    rd(0, 1, d); chk("R7 flush cleared word1", 64'(d), 64'h0);
  endtask

  task automatic t_transparent;
    logic [31:0] d;
    logic [NL-1:0] p;
    wr(12, 0, 32'h7);
    chk("R7 second flush replays line0", 64'(irq_out), 64'h1);
    wr(12, 0, 32'h0);
    p = 40'hA5_0000_1234;
    drive(p);
    chk("R8 pass-through pattern A", 64'(irq_out), 64'(p));
    p = 40'h5A_8000_0001;
    drive(p);
    chk("R8 pass-through pattern B", 64'(irq_out), 64'(p));
    rd(0, 0, d); chk("R4 disabled ignores edges", 64'(d), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_attr();
    t_record();
    t_ack();
    t_flush();
    t_transparent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule